// File: doc/BRIEF.md
# UART Byte FIFO Pair with Receive Trigger

This block holds the receive and transmit byte queues of a UART, each 16 entries deep. A single 8-bit control register configures both queues. One bit enables them. Two self-clearing bits empty either queue on its own. A 2-bit field chooses how many received characters must be waiting before the receive interrupt request rises. The serial engine pushes received bytes and pops bytes to send. The host side pops received bytes and pushes bytes to send. Each queue reports full, empty, its fill level and a sticky overrun flag.

A write that changes the enable bit, in either direction, empties both queues. While the queues are disabled, pushes and pops are ignored. The head entry of each queue is presented on its data output without a read delay, so a pop consumes the byte already visible.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Control bit 0 enables both queues. While it is 0, pushes and pops have no effect. A register write that changes bit 0, from 0 to 1 or from 1 to 0, empties both queues and clears both overrun flags, visible after that clock edge.
- R2: A write with bit 1 set empties the receive queue and clears its overrun flag. The transmit queue is not affected. Bit 1 is not stored and reads as 0.
- R3: A write with bit 2 set empties the transmit queue and clears its overrun flag. The receive queue is not affected. Bit 2 is not stored and reads as 0.
- R4: A write with bits 1 and 2 clear that keeps bit 0 unchanged leaves both queues' contents and levels unchanged.
- R5: Bits 7:6 are stored and select the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14 characters.
- R6: rx_irq_o is high exactly when the queues are enabled and rx_level_o is at or above the selected threshold. It follows the level in the same cycle, so a pop that takes the level below the threshold drops it after that edge.
- R7: After reset the control register reads 0x00. The readback shows bit 0 as the enable and bits 7:6 as the threshold select. Bits 5:1 always read 0, and written values in bits 5:3 have no effect.
- R8: Each queue returns bytes in push order and holds up to 16 bytes. Level, full (level 16) and empty (level 0) follow every accepted push and pop. A pop on an empty queue is ignored.
- R9: A push into a full queue is dropped, even when a pop arrives in the same cycle. It sets that queue's overrun flag, which stays set until that queue is emptied by R1 or by R2/R3.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full are both performed, and the level is unchanged.
- R11: When a write empties a queue, that emptying wins over a push or pop to the same queue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register readback |
| rx_push_i | input | 1 | Push into receive queue |
| rx_data_i | input | 8 | Receive push data |
| rx_pop_i | input | 1 | Pop from receive queue |
| rx_data_o | output | 8 | Receive queue head |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_level_o | output | 5 | Receive queue fill level |
| rx_ovr_o | output | 1 | Receive overrun, sticky |
| rx_irq_o | output | 1 | Receive threshold interrupt request |
| tx_push_i | input | 1 | Push into transmit queue |
| tx_data_i | input | 8 | Transmit push data |
| tx_pop_i | input | 1 | Pop from transmit queue |
| tx_data_o | output | 8 | Transmit queue head |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_level_o | output | 5 | Transmit queue fill level |
| tx_ovr_o | output | 1 | Transmit overrun, sticky |

## Verification
The assertions check the cycle-level rules on every cycle:
- the interrupt request against level, enable and threshold;
- emptying after an enable change or a reset bit;
- overrun setting on a push into a full queue;
- an unchanged level under a simultaneous push and pop;
- bounds on the level.

Only the bench's scenarios can show that bytes come out in push order with the right values. The same holds for R4, where a write without reset bits keeps the queues intact, and for the interplay of threshold changes with a filling and draining queue over long random runs.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int unsigned CFG_W   = 8;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned RXR_BIT = 1;
  localparam int unsigned TXR_BIT = 2;
  localparam int unsigned TRG_LSB = 6;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  typedef struct packed {
    trig_sel_e trig;
    logic      en;
  } fifo_cfg_t;

  function automatic int unsigned trig_thresh(input trig_sel_e sel);
    case (sel)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/fifo_cfg_reg.sv
module fifo_cfg_reg
  import uart_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output fifo_cfg_t        cfg_o,
  output logic             rx_flush_o,
  output logic             tx_flush_o,
  output logic [CFG_W-1:0] rdata_o
);

  fifo_cfg_t cfg_q;
  logic      en_chg;
  logic      unused_rsvd;

  // bits 5:3 carry no function
  assign unused_rsvd = ^wdata_i[5:3];

  assign en_chg = we_i && (wdata_i[EN_BIT] != cfg_q.en);

  // reset bits act on the write cycle only, never stored
  assign rx_flush_o = en_chg || (we_i && wdata_i[RXR_BIT]);
  assign tx_flush_o = en_chg || (we_i && wdata_i[TXR_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.en   <= wdata_i[EN_BIT];
      cfg_q.trig <= trig_sel_e'(wdata_i[TRG_LSB +: 2]);
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[EN_BIT]        = cfg_q.en;
    rdata_o[TRG_LSB +: 2]  = cfg_q.trig;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] level_o,
  output logic          ovr_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovr_q;
  logic          do_push, do_pop, drop;

  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);

  assign do_push = en_i && !flush_i && push_i && !full_o;
  assign do_pop  = en_i && !flush_i && pop_i  && !empty_o;
  assign drop    = en_i && !flush_i && push_i && full_o;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (drop) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  // head is visible without read latency
  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;
  assign ovr_o   = ovr_q;

endmodule

// File: rtl/rx_trigger.sv
module rx_trigger
  import uart_fifo_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          en_i,
  input  trig_sel_e     sel_i,
  input  logic [CW-1:0] level_i,
  output logic          irq_o
);

  logic [CW-1:0] thresh;

  assign thresh = CW'(trig_thresh(sel_i));
  assign irq_o  = en_i && (level_i >= thresh);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             rx_push_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic             rx_pop_i,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_full_o,
  output logic             rx_empty_o,
  output logic [CW-1:0]    rx_level_o,
  output logic             rx_ovr_o,
  output logic             rx_irq_o,
  input  logic             tx_push_i,
  input  logic [DW-1:0]    tx_data_i,
  input  logic             tx_pop_i,
  output logic [DW-1:0]    tx_data_o,
  output logic             tx_full_o,
  output logic             tx_empty_o,
  output logic [CW-1:0]    tx_level_o,
  output logic             tx_ovr_o
);

  localparam int unsigned NQ = 2;  // 0: receive, 1: transmit

  fifo_cfg_t     cfg;
  logic          rx_flush, tx_flush;
  logic          q_flush [NQ];
  logic          q_push  [NQ];
  logic          q_pop   [NQ];
  logic [DW-1:0] q_din   [NQ];
  logic [DW-1:0] q_dout  [NQ];
  logic          q_full  [NQ];
  logic          q_empty [NQ];
  logic [CW-1:0] q_level [NQ];
  logic          q_ovr   [NQ];

  fifo_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .cfg_o      (cfg),
    .rx_flush_o (rx_flush),
    .tx_flush_o (tx_flush),
    .rdata_o    (cfg_rdata_o)
  );

  assign q_flush[0] = rx_flush;
  assign q_push[0]  = rx_push_i;
  assign q_pop[0]   = rx_pop_i;
  assign q_din[0]   = rx_data_i;
  assign q_flush[1] = tx_flush;
  assign q_push[1]  = tx_push_i;
  assign q_pop[1]   = tx_pop_i;
  assign q_din[1]   = tx_data_i;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    byte_fifo #(
      .DW    (DW),
      .DEPTH (DEPTH)
    ) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (cfg.en),
      .flush_i (q_flush[g]),
      .push_i  (q_push[g]),
      .data_i  (q_din[g]),
      .pop_i   (q_pop[g]),
      .data_o  (q_dout[g]),
      .full_o  (q_full[g]),
      .empty_o (q_empty[g]),
      .level_o (q_level[g]),
      .ovr_o   (q_ovr[g])
    );
  end

  rx_trigger #(.CW(CW)) u_trig (
    .en_i    (cfg.en),
    .sel_i   (cfg.trig),
    .level_i (q_level[0]),
    .irq_o   (rx_irq_o)
  );

  assign rx_data_o  = q_dout[0];
  assign rx_full_o  = q_full[0];
  assign rx_empty_o = q_empty[0];
  assign rx_level_o = q_level[0];
  assign rx_ovr_o   = q_ovr[0];
  assign tx_data_o  = q_dout[1];
  assign tx_full_o  = q_full[1];
  assign tx_empty_o = q_empty[1];
  assign tx_level_o = q_level[1];
  assign tx_ovr_o   = q_ovr[1];

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             rx_push_i,
  input logic             rx_pop_i,
  input logic             rx_full_o,
  input logic             rx_empty_o,
  input logic [CW-1:0]    rx_level_o,
  input logic             rx_ovr_o,
  input logic             rx_irq_o,
  input logic             tx_empty_o,
  input logic [CW-1:0]    tx_level_o,
  input logic             tx_ovr_o
);

  logic en_now;
  assign en_now = cfg_rdata_o[EN_BIT];

  a_r1_toggle_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_wdata_i[EN_BIT] != en_now)
    |=> rx_empty_o && tx_empty_o && !rx_ovr_o && !tx_ovr_o);

  a_r1_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_now && !cfg_we_i |=> $stable(rx_level_o) && $stable(tx_level_o));

  a_r2_rx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_wdata_i[RXR_BIT] |=> rx_empty_o && !rx_ovr_o);

  a_r3_tx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_wdata_i[TXR_BIT] |=> tx_empty_o && !tx_ovr_o);

  a_r6_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o == (en_now &&
      (rx_level_o >= CW'(trig_thresh(trig_sel_e'(cfg_rdata_o[TRG_LSB +: 2]))))));

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level_o <= CW'(DEPTH) && tx_level_o <= CW'(DEPTH));

  a_r9_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_now && !cfg_we_i && rx_full_o && rx_push_i |=> rx_ovr_o);

  a_r10_push_pop_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_now && !cfg_we_i && rx_push_i && rx_pop_i && !rx_empty_o && !rx_full_o
    |=> $stable(rx_level_o));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .rx_push_i   (rx_push_i),
  .rx_pop_i    (rx_pop_i),
  .rx_full_o   (rx_full_o),
  .rx_empty_o  (rx_empty_o),
  .rx_level_o  (rx_level_o),
  .rx_ovr_o    (rx_ovr_o),
  .rx_irq_o    (rx_irq_o),
  .tx_empty_o  (tx_empty_o),
  .tx_level_o  (tx_level_o),
  .tx_ovr_o    (tx_ovr_o)
);

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;

  localparam int DEPTH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [7:0] rx_data_i = '0, rx_data_o;
  logic       rx_full_o, rx_empty_o, rx_ovr_o, rx_irq_o;
  logic [4:0] rx_level_o;
  logic       tx_push_i = 1'b0, tx_pop_i = 1'b0;
  logic [7:0] tx_data_i = '0, tx_data_o;
  logic       tx_full_o, tx_empty_o, tx_ovr_o;
  logic [4:0] tx_level_o;

  always #2.5 clk_i = ~clk_i;

  uart_fifo_ctrl dut (.*);

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  logic [7:0] rxq[$], txq[$];
  bit         m_en, m_rxo, m_txo;
  bit [1:0]   m_trig;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int thresh(bit [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic model_step();
    bit fl_rx, fl_tx;
    int rs, ts;
    fl_rx = cfg_we_i && (cfg_wdata_i[1] || (cfg_wdata_i[0] != m_en));
    fl_tx = cfg_we_i && (cfg_wdata_i[2] || (cfg_wdata_i[0] != m_en));
    rs = rxq.size();
    ts = txq.size();
    if (fl_rx) begin
      rxq.delete(); m_rxo = 0;
    end else if (m_en) begin
      if (rx_pop_i && rs > 0) void'(rxq.pop_front());
      if (rx_push_i) begin
        if (rs == DEPTH) m_rxo = 1; else rxq.push_back(rx_data_i);
      end
    end
    if (fl_tx) begin
      txq.delete(); m_txo = 0;
    end else if (m_en) begin
      if (tx_pop_i && ts > 0) void'(txq.pop_front());
      if (tx_push_i) begin
        if (ts == DEPTH) m_txo = 1; else txq.push_back(tx_data_i);
      end
    end
    if (cfg_we_i) begin
      m_en   = cfg_wdata_i[0];
      m_trig = cfg_wdata_i[7:6];
    end
  endtask

  task automatic compare();
    int  rs, ts;
    bit  exp_irq;
    logic [7:0] exp_cfg;
    rs = rxq.size();
    ts = txq.size();
    exp_irq = m_en && (rs >= thresh(m_trig));
    exp_cfg = {m_trig, 5'b0, m_en};
    chk(rx_level_o == rs, "R8", "rx_level", rx_level_o, rs);
    chk(tx_level_o == ts, "R8", "tx_level", tx_level_o, ts);
    chk({rx_full_o, rx_empty_o} == {rs == DEPTH, rs == 0}, "R8", "rx_flags",
        {rx_full_o, rx_empty_o}, {rs == DEPTH, rs == 0});
    chk({tx_full_o, tx_empty_o} == {ts == DEPTH, ts == 0}, "R8", "tx_flags",
        {tx_full_o, tx_empty_o}, {ts == DEPTH, ts == 0});
    if (rs > 0) chk(rx_data_o == rxq[0], "R8", "rx_head", rx_data_o, rxq[0]);
    if (ts > 0) chk(tx_data_o == txq[0], "R8", "tx_head", tx_data_o, txq[0]);
    chk(rx_ovr_o == m_rxo, "R9", "rx_ovr", rx_ovr_o, m_rxo);
    chk(tx_ovr_o == m_txo, "R9", "tx_ovr", tx_ovr_o, m_txo);
    chk(rx_irq_o == exp_irq, "R6", "rx_irq", rx_irq_o, exp_irq);
    chk(cfg_rdata_o == exp_cfg, "R7", "cfg_rdata", cfg_rdata_o, exp_cfg);
  endtask

  // called at a falling edge; applies inputs for one clock
  task automatic op(bit we, logic [7:0] wd, bit rp, logic [7:0] rd, bit rpo,
                    bit tp, logic [7:0] td, bit tpo);
    cfg_we_i = we; cfg_wdata_i = wd;
    rx_push_i = rp; rx_data_i = rd; rx_pop_i = rpo;
    tx_push_i = tp; tx_data_i = td; tx_pop_i = tpo;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    cfg_we_i = 0; rx_push_i = 0; rx_pop_i = 0; tx_push_i = 0; tx_pop_i = 0;
    compare();
  endtask

  task automatic wr(logic [7:0] wd);
    op(1, wd, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rxpush(logic [7:0] d);
    op(0, 0, 1, d, 0, 0, 0, 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int bias;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7 reset state
    chk(cfg_rdata_o == 8'h00, "R7", "reset_cfg", cfg_rdata_o, 0);
    compare();

    // R1 disabled pushes ignored
    rxpush(8'h11);
    chk(rx_empty_o == 1, "R1", "disabled_push", rx_empty_o, 1);

    wr(8'h01);
    for (int i = 0; i < DEPTH; i++) rxpush(8'(i * 7 + 3));
    chk(rx_full_o == 1, "R8", "fill_full", rx_full_o, 1);
    // R9 overflow dropped even with pop
    op(0, 0, 1, 8'hEE, 1, 0, 0, 0);
    chk(rx_ovr_o == 1 && rx_level_o == 15, "R9", "full_push_pop",
        {rx_ovr_o, rx_level_o}, {1'b1, 5'd15});
    rxpush(8'h44);
    rxpush(8'h45);
    chk(rx_ovr_o == 1, "R9", "ovr_sticky", rx_ovr_o, 1);

    for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 0, 1, 8'(8'hA0 + i), 0);
    // R4 plain write keeps contents; bits 5:3 ignored
    wr(8'h39);
    chk(rx_level_o == 16 && tx_level_o == 3, "R4", "plain_write",
        rx_level_o + tx_level_o, 19);
    chk(cfg_rdata_o == 8'h01, "R7", "rsvd_read", cfg_rdata_o, 8'h01);

    wr(8'h05);
    chk(tx_empty_o == 1 && rx_level_o == 16, "R3", "tx_reset",
        {tx_empty_o, rx_level_o}, {1'b1, 5'd16});
    wr(8'h03);
    chk(rx_empty_o == 1 && rx_ovr_o == 0, "R2", "rx_reset",
        {rx_empty_o, rx_ovr_o}, 2'b10);

    rxpush(8'h01);
    rxpush(8'h02);
    op(0, 0, 1, 8'h03, 1, 0, 0, 0);
    chk(rx_level_o == 2 && rx_data_o == 8'h02, "R10", "push_pop",
        {rx_level_o, rx_data_o}, {5'd2, 8'h02});
    op(1, 8'h03, 1, 8'h77, 0, 0, 0, 0);
    chk(rx_level_o == 0, "R11", "flush_wins", rx_level_o, 0);

    rxpush(8'h10);
    op(0, 0, 0, 0, 0, 1, 8'h20, 0);
    wr(8'h00);
    chk(rx_empty_o && tx_empty_o, "R1", "disable_flush",
        {rx_empty_o, tx_empty_o}, 2'b11);
    wr(8'h01);

    wr(8'hC1);
    for (int i = 0; i < 13; i++) rxpush(8'(i));
    chk(rx_irq_o == 0, "R5", "trig14_below", rx_irq_o, 0);
    rxpush(8'hFF);
    chk(rx_irq_o == 1, "R5", "trig14_reached", rx_irq_o, 1);
    op(0, 0, 0, 0, 1, 0, 0, 0);
    chk(rx_irq_o == 0, "R6", "pop_below", rx_irq_o, 0);
    wr(8'h81);
    chk(rx_irq_o == 1, "R5", "trig8", rx_irq_o, 1);

    // random phase
    bias = 60;
    for (int c = 0; c < 6000; c++) begin
      logic [7:0] wd;
      bit we;
      if (c % 500 == 0) bias = (c / 500 % 3 == 0) ? 30 : (c / 500 % 3 == 1) ? 60 : 85;
      we = ($urandom % 20) == 0;
      wd = 8'($urandom);
      wd[0] = ($urandom % 10) != 0;
      if ($urandom % 4 != 0) wd[2:1] = 2'b00;
      op(we, wd,
         ($urandom % 100) < bias, 8'($urandom), ($urandom % 100) < (100 - bias),
         ($urandom % 100) < bias, 8'($urandom), ($urandom % 100) < (100 - bias));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule